// File: doc/BRIEF.md
# HSync-Counted Raster Interrupt Generator

This block turns the horizontal sync stream of a video timing controller into a periodic interrupt request for the CPU. It counts the starts of horizontal sync pulses and raises a request every 52 of them. A rising vertical sync re-phases the cadence, so the first request of each frame lands two lines after the vertical sync began. The cadence is driven only by horizontal sync. A line programmed without a sync pulse therefore does not advance the count and produces no request.

The same block holds the video mode. A CPU write of a new 2-bit mode value is parked as pending. The visible mode changes only at the start of the next horizontal sync, so a mode switch never happens part-way through a line. Every input is sampled only in cycles where the clock enable is high. This lets the block run from a fast system clock while following a slower character clock.

Top module: `hsync_raster_irq`

## Requirements
- R1: After reset, `irq` is 0, `mode` is 0, the line count is 0, no re-phase is armed and no mode write is pending.
- R2: Inputs are sampled only on clock edges where `ce` is 1. When `ce` is 0, hsync, vsync, acknowledge and mode writes have no effect, and `irq` and `mode` hold.
- R3: A horizontal sync start is a sample of `hsync` at 1 whose previous enabled sample was 0. Each start adds one to the line count. The start that would make the count 52 instead clears it to 0 and raises `irq`, which reads 1 from the cycle after that sampling edge.
- R4: With no horizontal sync start, `irq` never rises and the line count does not advance.
- R5: `irq` stays high until an acknowledge sample (`irq_ack`=1 with `ce`=1). The acknowledge clears `irq` and bit 5 of the line count (the value-32 bit), whether or not a request was pending. If a request is raised on the same sample, the raise wins.
- R6: A vertical sync start (`vsync` sampled 1 after an enabled 0) arms a re-phase. The second horizontal sync start after it sets the line count to 0. That start raises `irq` if the count, after any same-sample acknowledge mask, was 32 or more just before it. A horizontal sync start on the same sample as the vertical sync start is counted normally and is not one of the two.
- R7: A new vertical sync start while a re-phase is armed restarts the two-hsync wait.
- R8: A mode write (`mode_we`=1 with `ce`=1) stores `mode_wdata` as pending, and a later write replaces it. At the next horizontal sync start the pending value becomes `mode` from the following cycle. A write on the same sample as a horizontal sync start waits for the next one.
- R9: With no horizontal sync start, `mode` does not change, whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce | input | 1 | Clock enable; inputs are sampled only when high |
| hsync | input | 1 | Horizontal sync level from the video timing controller |
| vsync | input | 1 | Vertical sync level from the video timing controller |
| irq_ack | input | 1 | Interrupt acknowledge strobe |
| mode_we | input | 1 | Video mode write strobe |
| mode_wdata | input | 2 | Video mode value to be written |
| irq | output | 1 | Interrupt request to the CPU |
| mode | output | 2 | Active video mode |

## Verification
The bench first drives long runs of evenly spaced sync pulses with no acknowledge, which shows whether the 52-line wrap sits on the right pulse. It then drives long quiet stretches with no hsync, which separates a design that counts time or enable cycles from one that counts sync starts. Directed vertical sync cases put the re-phase point at counts below and above 32, line up vsync and hsync on the same sample, and re-arm during the wait. These separate a two-hsync re-phase from off-by-one variants, and the threshold decision from an unconditional request. Random line lengths, gated clock enables, random acknowledges and mode writes, some on the same sample as an hsync start, then exercise the acknowledge mask and the deferred mode update against a reference model in the bench.

// File: rtl/rirq_pkg.sv
package rirq_pkg;

   typedef struct packed {
      logic hs;
      logic vs;
      logic ack;
      logic we;
   } rirq_step_t;

endpackage

// File: rtl/rirq_edge.sv
module rirq_edge #(
   parameter bit FALLING = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ce,
   input  logic lvl,
   output logic edge_o
);

   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else if (ce) lvl_q <= lvl;
   end

   generate
      if (FALLING) begin : g_fall
         assign edge_o = ce & ~lvl & lvl_q;
      end else begin : g_rise
         assign edge_o = ce & lvl & ~lvl_q;
      end
   endgenerate

endmodule

// File: rtl/rirq_line_ctr.sv
module rirq_line_ctr #(
   parameter int CNT_W    = 6,
   parameter int PERIOD   = 52,
   parameter int VS_DELAY = 2,
   parameter int ACK_BIT  = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hs_step,
   input  logic vs_step,
   input  logic ack_step,
   output logic irq_o
);

   localparam int AW = $clog2(VS_DELAY + 1);
   localparam logic [CNT_W-1:0] LAST    = CNT_W'(PERIOD - 1);
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
   localparam logic [CNT_W-1:0] HALFBIT = ONE << ACK_BIT;
   localparam logic [AW-1:0]    A_INIT  = AW'(VS_DELAY);
   localparam logic [AW-1:0]    A_ONE   = AW'(1);

   generate
      if (PERIOD < 2 || PERIOD > (1 << CNT_W)) begin : g_bad_period
         $error("rirq_line_ctr: PERIOD does not fit CNT_W");
      end
      if (ACK_BIT >= CNT_W || (1 << ACK_BIT) >= PERIOD) begin : g_bad_bit
         $error("rirq_line_ctr: ACK_BIT must name a bit below PERIOD");
      end
      if (VS_DELAY < 1) begin : g_bad_delay
         $error("rirq_line_ctr: VS_DELAY must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q, cnt_d, base;
   logic [AW-1:0]    arm_q, arm_d;
   logic             irq_q, irq_d, raise, rephase;

   always_comb begin
      base    = ack_step ? (cnt_q & ~HALFBIT) : cnt_q;
      rephase = hs_step && (arm_q == A_ONE) && !vs_step;
      raise   = 1'b0;
      cnt_d   = base;
      if (hs_step) begin
         if (rephase) begin
            cnt_d = '0;
            raise = (base >= HALFBIT);
         end else if (base == LAST) begin
            cnt_d = '0;
            raise = 1'b1;
         end else begin
            cnt_d = base + ONE;
         end
      end
      arm_d = arm_q;
      if (vs_step) arm_d = A_INIT;
      else if (hs_step && arm_q != '0) arm_d = arm_q - A_ONE;
      irq_d = (irq_q & ~ack_step) | raise;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         arm_q <= '0;
         irq_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         arm_q <= arm_d;
         irq_q <= irq_d;
      end
   end

   assign irq_o = irq_q;

   p_irq_needs_hsync_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> $past(hs_step));

   p_count_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!hs_step && !ack_step) |=> (cnt_q == $past(cnt_q)));

   p_count_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

   p_wrap_raise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_step && !rephase && base == LAST) |=> (irq_q && cnt_q == '0));

   p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_step && !hs_step) |=> (!irq_q && !cnt_q[ACK_BIT]));

   p_rephase_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rephase && base >= HALFBIT) |=> (irq_q && cnt_q == '0));

endmodule

// File: rtl/rirq_mode_latch.sv
module rirq_mode_latch #(
   parameter int             MODE_W     = 2,
   parameter logic [MODE_W-1:0] RESET_MODE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hs_step,
   input  logic              we_step,
   input  logic [MODE_W-1:0] wdata,
   output logic [MODE_W-1:0] mode_o
);

   generate
      if (MODE_W < 1) begin : g_bad_w
         $error("rirq_mode_latch: MODE_W must be positive");
      end
   endgenerate

   logic [MODE_W-1:0] pend_q, mode_q;
   logic              pv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= RESET_MODE;
         pv_q   <= 1'b0;
         mode_q <= RESET_MODE;
      end else begin
         if (hs_step && pv_q) begin
            mode_q <= pend_q;
            pv_q   <= 1'b0;
         end
         if (we_step) begin
            pend_q <= wdata;
            pv_q   <= 1'b1;
         end
      end
   end

   assign mode_o = mode_q;

   p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !hs_step |=> $stable(mode_q));

   p_mode_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_step && pv_q) |=> (mode_q == $past(pend_q)));

endmodule

// File: rtl/hsync_raster_irq.sv
module hsync_raster_irq #(
   parameter int  CNT_W        = 6,
   parameter int  PERIOD       = 52,
   parameter int  VS_DELAY     = 2,
   parameter int  ACK_BIT      = 5,
   parameter int  MODE_W       = 2,
   parameter bit  COUNT_ON_END = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce,
   input  logic              hsync,
   input  logic              vsync,
   input  logic              irq_ack,
   input  logic              mode_we,
   input  logic [MODE_W-1:0] mode_wdata,
   output logic              irq,
   output logic [MODE_W-1:0] mode
);

   rirq_pkg::rirq_step_t stp;
   logic hs_edge, vs_edge;

   rirq_edge #(.FALLING(COUNT_ON_END)) u_hs_edge (
      .clk(clk), .rst_n(rst_n), .ce(ce), .lvl(hsync), .edge_o(hs_edge)
   );

   rirq_edge #(.FALLING(1'b0)) u_vs_edge (
      .clk(clk), .rst_n(rst_n), .ce(ce), .lvl(vsync), .edge_o(vs_edge)
   );

   assign stp.hs  = hs_edge;
   assign stp.vs  = vs_edge;
   assign stp.ack = ce & irq_ack;
   assign stp.we  = ce & mode_we;

   rirq_line_ctr #(
      .CNT_W(CNT_W), .PERIOD(PERIOD), .VS_DELAY(VS_DELAY), .ACK_BIT(ACK_BIT)
   ) u_ctr (
      .clk(clk), .rst_n(rst_n),
      .hs_step(stp.hs), .vs_step(stp.vs), .ack_step(stp.ack),
      .irq_o(irq)
   );

   rirq_mode_latch #(.MODE_W(MODE_W)) u_mode (
      .clk(clk), .rst_n(rst_n),
      .hs_step(stp.hs), .we_step(stp.we), .wdata(mode_wdata),
      .mode_o(mode)
   );

   p_ce_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !ce |=> ($stable(irq) && $stable(mode)));

endmodule

// File: tb/sim_hsync_raster_irq.sv
module sim_hsync_raster_irq;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce = 1'b0, hs = 1'b0, vs = 1'b0, ack = 1'b0, we = 1'b0;
   logic [1:0] wd = 2'd0;
   logic irq;
   logic [1:0] mode;

   always #2 clk = ~clk;

   hsync_raster_irq u0 (
      .clk(clk), .rst_n(rst_n), .ce(ce), .hsync(hs), .vsync(vs),
      .irq_ack(ack), .mode_we(we), .mode_wdata(wd), .irq(irq), .mode(mode)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   string tag = "R1";

   // reference state, from the requirements
   logic [5:0] m_cnt = 6'd0;
   int         m_arm = 0;
   logic       m_irq = 1'b0, m_hsq = 1'b0, m_vsq = 1'b0, m_pv = 1'b0;
   logic [1:0] m_mode = 2'd0, m_pend = 2'd0;

   task automatic model(input logic h, input logic v, input logic a,
                        input logic w, input logic [1:0] d, input logic c);
      logic he, ve, raise, reph;
      logic [5:0] base;
      if (!c) return;
      he = h & ~m_hsq;
      ve = v & ~m_vsq;
      m_hsq = h;
      m_vsq = v;
      base  = a ? (m_cnt & 6'b011111) : m_cnt;
      raise = 1'b0;
      reph  = he && (m_arm == 1) && !ve;
      m_cnt = base;
      if (he) begin
         if (reph) begin
            raise = (base >= 6'd32);
            m_cnt = 6'd0;
         end else if (base == 6'd51) begin
            raise = 1'b1;
            m_cnt = 6'd0;
         end else begin
            m_cnt = base + 6'd1;
         end
      end
      if (ve) m_arm = 2;
      else if (he && m_arm != 0) m_arm = m_arm - 1;
      m_irq = (m_irq & ~a) | raise;
      if (he && m_pv) begin
         m_mode = m_pend;
         m_pv   = 1'b0;
      end
      if (w) begin
         m_pend = d;
         m_pv   = 1'b1;
      end
   endtask

   task automatic chk(input string t, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s got %0d expected %0d", t, got, exp);
      end
   endtask

   // one sample: compare last result, drive new inputs, advance model
   task automatic st(input logic h, input logic v, input logic a,
                     input logic w, input logic [1:0] d, input logic c);
      @(negedge clk);
      chk({tag, " irq"}, int'(irq), int'(m_irq));
      chk({tag, " mode"}, int'(mode), int'(m_mode));
      hs = h; vs = v; ack = a; we = w; wd = d; ce = c;
      model(h, v, a, w, d, c);
   endtask

   // directed check against a constant, leaving inputs idle
   task automatic dchk(input string t, input int exp_irq, input int exp_mode);
      @(negedge clk);
      chk({t, " irq"}, int'(irq), exp_irq);
      if (exp_mode >= 0) chk({t, " mode"}, int'(mode), exp_mode);
      ce = 1'b0; ack = 1'b0; we = 1'b0;
   endtask

   task automatic pulse(input int n);
      for (int i = 0; i < n; i++) begin
         st(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1);
         st(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1);
      end
   endtask

   task automatic do_ack();
      st(1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b1);
      st(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(4 * 190000);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int seed;
      int len, hw;
      logic v_lvl;
      seed = 32'h5eed_1234;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      tag = "R1";
      dchk("R1 reset", 0, 0);

      tag = "R3 cadence";
      pulse(51);
      dchk("R3 after 51 hsyncs", 0, -1);
      pulse(1);
      dchk("R3 after 52 hsyncs", 1, -1);

      tag = "R5 ack";
      do_ack();
      dchk("R5 ack clears irq", 0, -1);

      tag = "R4 R9 quiet";
      st(1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 1'b1);
      for (int i = 0; i < 300; i++) st(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1);
      dchk("R4 no hsync no irq", 0, -1);
      dchk("R9 no hsync mode held", 0, 0);
      pulse(1);
      dchk("R8 mode at hsync", 0, 3);

      tag = "R2 ce low";
      for (int i = 0; i < 60; i++) begin
         st(1'b1, 1'b1, 1'b1, 1'b1, 2'd2, 1'b0);
         st(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
      end
      pulse(1);
      dchk("R2 ce low ignored", 0, 3);

      tag = "R5 halfbit";
      pulse(38);
      do_ack();
      pulse(43);
      dchk("R5 count masked, 43 more", 0, -1);
      pulse(1);
      dchk("R5 count masked, 44 more", 1, -1);
      do_ack();

      tag = "R6 below";
      pulse(10);
      st(1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1);
      st(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1);
      pulse(2);
      dchk("R6 rephase below 32 no irq", 0, -1);
      pulse(51);
      dchk("R6 count restarted, 51", 0, -1);
      pulse(1);
      dchk("R6 count restarted, 52", 1, -1);
      do_ack();

      tag = "R6 above";
      pulse(35);
      st(1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1);
      st(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1);
      pulse(1);
      dchk("R6 one hsync after vsync", 0, -1);
      pulse(1);
      dchk("R6 rephase above 32 irq", 1, -1);
      do_ack();
      pulse(40);
      st(1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1);
      st(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1);
      pulse(1);
      dchk("R6 coincident hsync not counted", 0, -1);
      pulse(1);
      dchk("R6 rephase after coincident", 1, -1);
      do_ack();

      tag = "R7 rearm";
      pulse(40);
      st(1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1);
      st(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1);
      pulse(1);
      st(1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1);
      st(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1);
      pulse(1);
      dchk("R7 rearmed, one hsync", 0, -1);
      pulse(1);
      dchk("R7 rearmed, two hsyncs", 1, -1);
      do_ack();

      tag = "R8 defer";
      st(1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 1'b1);
      st(1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 1'b1);
      st(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1);
      dchk("R8 old pending applied", -1 == 0 ? 0 : int'(m_irq), 1);
      pulse(1);
      dchk("R8 coincident write next hsync", int'(m_irq), 2);
      st(1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1);
      st(1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 1'b1);
      pulse(1);
      dchk("R8 last write wins", int'(m_irq), 3);

      tag = "R3/R5/R6/R8 random";
      v_lvl = 1'b0;
      for (int ln = 0; ln < 700; ln++) begin
         len = 6 + int'($urandom_range(0, 8));
         hw  = 1 + int'($urandom_range(0, 2));
         if (ln % 97 == 5) v_lvl = 1'b1;
         if (ln % 97 == 9) v_lvl = 1'b0;
         for (int s = 0; s < len; s++) begin
            logic h, c, a, w;
            logic [1:0] d;
            h = (s < hw) && !(ln % 41 == 3);
            c = ($urandom_range(0, 9) < 8);
            a = m_irq ? ($urandom_range(0, 9) < 3) : ($urandom_range(0, 99) < 2);
            w = ($urandom_range(0, 19) == 0);
            d = 2'($urandom_range(0, 3));
            st(h, v_lvl, a, w, d, c);
         end
      end
      st(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
      dchk("R3 random end state", int'(m_irq), int'(m_mode));

      finish_run();
   end

endmodule